// File: doc/BRIEF.md
# Banked Pin Controller with Edge Interrupts

This block is a memory-mapped controller for 71 general-purpose pins. The pins are grouped into banks of 32. Pin n belongs to bank n/32 and sits at bit n%32 of that bank, so the third bank uses only its seven lowest bits. Each bank has a window of ten word registers on a simple 32-bit register bus. The bus has an address, a write strobe, write data and a read data path that is combinational. Software controls pin direction and the output latch through these registers. It can change single output bits with write-one set and write-one clear registers, and it reads the pin levels after they pass through a synchronizer clocked by the controller clock.

Each pin can arm rising-edge detection and falling-edge detection on its own. Each kind of edge has its own set register and its own clear register. A detected edge on an armed pin latches a status bit. Each status bit drives that pin's interrupt line, and each bank also has one line that is the OR of its status bits. Software clears a status bit by writing a one to it.

Top module: `bankio_ctrl`

## Requirements
- R1: After reset every pin is an input: pin_oe is all zero, pin_out is all zero, every interrupt line is low, the direction register of banks 0 and 1 reads 0xFFFFFFFF and the direction register of bank 2 reads 0x0000007F.
- R2: Bank b's window starts at byte address 0x10 + 0x28*b. The ten registers sit at byte offsets 4*k inside the window, with k numbered as follows: 0 direction, 1 output latch, 2 set, 3 clear, 4 input level, 5 rising-arm set, 6 rising-arm clear, 7 falling-arm set, 8 falling-arm clear, 9 status.
- R3: A direction bit of 1 turns the pin's driver off (pin_oe low). A direction bit of 0 makes the pin drive its output latch bit (pin_oe high). The direction register is loaded by a write to k=0.
- R4: A write to the set register (k=2) makes every output latch bit written as 1 go high and leaves the other bits unchanged.
- R5: A write to the clear register (k=3) makes every output latch bit written as 1 go low and leaves the other bits unchanged.
- R6: A write to k=1 loads the whole output latch. A read of k=1, k=2 or k=3 returns the current output latch.
- R7: The input level register (k=4) returns the pin level after two controller clock edges, whatever the pin's direction. A read taken right after the pin changes still returns the old level.
- R8: A write to k=5 arms rising-edge detection for the bits written as 1. A write to k=6 disarms them. A read of either register returns the current rising-arm mask.
- R9: A write to k=7 arms falling-edge detection for the bits written as 1. A write to k=8 disarms them. A read of either register returns the current falling-arm mask.
- R10: When the synchronized level of a pin changes in a direction that is armed, the pin's status bit (k=9) goes high three clock edges after the pin changed. pin_irq carries the status bits and bank_irq[b] is the OR of bank b's status bits. Edges in a direction that is not armed leave the status unchanged.
- R11: Writing a 1 to a status bit clears it. Status bits written as 0 are kept. An edge that is detected in the same cycle as the clear wins.
- R12: Reads of unmapped or misaligned addresses, and of bank 2 bits 7 to 31, return zero. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; it also clocks the pin sampling |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 71 | Pin levels as seen at the pads |
| pin_out | output | 71 | Output latch value for each pin |
| pin_oe | output | 71 | Driver enable for each pin, high when the pin drives |
| pin_irq | output | 71 | Interrupt status for each pin |
| bank_irq | output | 3 | OR of the status bits of each bank |

## Verification
A wrong output latch or direction bit shows on pin_out or pin_oe right after the write edge, because both outputs come straight from registers. A fault in the synchronizer depth shows as an input level read that changes one edge early or one edge late. A fault in edge detection or in the arm masks shows as an interrupt line that rises in a cycle other than the third edge after the pin change, or that rises on an edge in a direction that is not armed. A decode fault shows as data that reads back from the wrong bank or register, or as an unmapped address that returns nonzero data.

// File: rtl/bankio_pkg.sv
package bankio_pkg;

  typedef enum logic [3:0] {
    REG_DIR      = 4'd0,
    REG_OUT      = 4'd1,
    REG_SET      = 4'd2,
    REG_CLR      = 4'd3,
    REG_IN       = 4'd4,
    REG_RISE_SET = 4'd5,
    REG_RISE_CLR = 4'd6,
    REG_FALL_SET = 4'd7,
    REG_FALL_CLR = 4'd8,
    REG_STAT     = 4'd9
  } reg_idx_e;

  localparam int unsigned REGS_PER_BANK = 10;

  typedef struct packed {
    logic      hit;
    logic [7:0] bank;
    reg_idx_e  idx;
  } dec_t;

  // Map a byte address to (bank, register); hit is low for anything unmapped.
  function automatic dec_t decode(input logic [31:0] addr, input int unsigned base,
                                  input int unsigned stride, input int unsigned banks);
    dec_t d;
    int unsigned off, bk, ri;
    d.hit  = 1'b0;
    d.bank = '0;
    d.idx  = REG_DIR;
    if (addr[1:0] == 2'b00 && addr >= base) begin
      off = addr - base;
      bk  = off / stride;
      ri  = (off % stride) / 4;
      if (bk < banks && ri < REGS_PER_BANK) begin
        d.hit  = 1'b1;
        d.bank = 8'(bk);
        d.idx  = reg_idx_e'(ri[3:0]);
      end
    end
    return d;
  endfunction

  // Number of pins present in bank b.
  function automatic int unsigned bank_width(input int unsigned b, input int unsigned pins,
                                             input int unsigned w);
    return (pins - b * w) < w ? (pins - b * w) : w;
  endfunction

endpackage

// File: rtl/bankio_sync.sv
module bankio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/bankio_bank.sv
module bankio_bank
  import bankio_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_idx_e     idx,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_raw,
  output logic [31:0]  rdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] edge_evt
);
  logic [W-1:0] smp, prev, rise_en, fall_en, clr_mask;

  bankio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(smp)
  );

  // Named event: armed edge seen between the last two samples.
  assign edge_evt = (smp & ~prev & rise_en) | (~smp & prev & fall_en);
  assign clr_mask = (wr_en && idx == REG_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= '0;
      dir_q   <= '1;
      out_q   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      stat_q  <= '0;
    end else begin
      prev   <= smp;
      stat_q <= (stat_q & ~clr_mask) | edge_evt;
      if (wr_en) begin
        case (idx)
          REG_DIR:      dir_q   <= wdata;
          REG_OUT:      out_q   <= wdata;
          REG_SET:      out_q   <= out_q | wdata;
          REG_CLR:      out_q   <= out_q & ~wdata;
          REG_RISE_SET: rise_en <= rise_en | wdata;
          REG_RISE_CLR: rise_en <= rise_en & ~wdata;
          REG_FALL_SET: fall_en <= fall_en | wdata;
          REG_FALL_CLR: fall_en <= fall_en & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      REG_DIR:                       rdata = 32'(dir_q);
      REG_OUT, REG_SET, REG_CLR:     rdata = 32'(out_q);
      REG_IN:                        rdata = 32'(smp);
      REG_RISE_SET, REG_RISE_CLR:    rdata = 32'(rise_en);
      REG_FALL_SET, REG_FALL_CLR:    rdata = 32'(fall_en);
      REG_STAT:                      rdata = 32'(stat_q);
      default:                       rdata = '0;
    endcase
  end
endmodule

// File: rtl/bankio_ctrl.sv
module bankio_ctrl
  import bankio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 71,
  parameter int unsigned BANK_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WIN_BASE    = 32'h10,
  parameter int unsigned WIN_STRIDE  = 32'h28,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_irq,
  output logic [(NUM_PINS+BANK_W-1)/BANK_W-1:0] bank_irq
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  dec_t                dec;
  logic [31:0]         bank_rd [NUM_BANKS];
  logic [NUM_PINS-1:0] dir_all;
  logic [NUM_PINS-1:0] edge_evt;

  assign dec = decode(32'(bus_addr), WIN_BASE, WIN_STRIDE, NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BW = bank_width(b, NUM_PINS, BANK_W);
    localparam int unsigned LO = b * BANK_W;
    logic sel;
    assign sel = bus_we && dec.hit && dec.bank == 8'(b);

    bankio_bank #(.W(BW), .STAGES(SYNC_STAGES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel),
      .idx      (dec.idx),
      .wdata    (bus_wdata[BW-1:0]),
      .pin_raw  (pin_in[LO +: BW]),
      .rdata    (bank_rd[b]),
      .out_q    (pin_out[LO +: BW]),
      .dir_q    (dir_all[LO +: BW]),
      .stat_q   (pin_irq[LO +: BW]),
      .edge_evt (edge_evt[LO +: BW])
    );
    assign bank_irq[b] = |pin_irq[LO +: BW];
  end

  assign pin_oe = ~dir_all;

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (dec.hit && dec.bank == 8'(b)) bus_rdata = bank_rd[b];
  end
endmodule

// File: rtl/bankio_ctrl_chk.sv
module bankio_ctrl_chk
  import bankio_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 71,
  parameter int unsigned BANK_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned WIN_BASE   = 32'h10,
  parameter int unsigned WIN_STRIDE = 32'h28
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_irq,
  input logic [NUM_PINS-1:0] edge_evt
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned BW0 = bank_width(0, NUM_PINS, BANK_W);

  dec_t d;
  logic w0, w_any_dir;
  assign d         = decode(32'(bus_addr), WIN_BASE, WIN_STRIDE, NUM_BANKS);
  assign w0        = bus_we && d.hit && d.bank == 8'd0;
  assign w_any_dir = bus_we && d.hit && d.idx == REG_DIR;

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && d.idx == REG_SET) |=> pin_out[BW0-1:0] == ($past(pin_out[BW0-1:0]) | $past(bus_wdata[BW0-1:0]))); // R4

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && d.idx == REG_CLR) |=> pin_out[BW0-1:0] == ($past(pin_out[BW0-1:0]) & ~$past(bus_wdata[BW0-1:0]))); // R5

  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !w_any_dir |=> $stable(pin_oe)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !d.hit |-> bus_rdata == 32'd0); // R12

  AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_irq & ~$past(pin_irq) & ~$past(edge_evt)) == '0); // R10

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && d.idx == REG_STAT) |=> (pin_irq[BW0-1:0] & $past(bus_wdata[BW0-1:0]) & ~$past(edge_evt[BW0-1:0])) == '0); // R11
endmodule

bind bankio_ctrl bankio_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
  .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_irq(pin_irq), .edge_evt(edge_evt)
);

// File: tb/bankio_ctrl_test.sv
`timescale 1ns/1ps
module bankio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [70:0] pin_in = '0;
  logic [70:0] pin_out, pin_oe, pin_irq;
  logic [2:0]  bank_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bankio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq), .bank_irq(bank_irq)
  );

  function automatic logic [7:0] ra(input int b, input int k);
    return 8'(16 + 40 * b + 4 * k);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 oe", 128'(pin_oe), 0);
    chk("R1 out", 128'(pin_out), 0);
    chk("R1 irq", 128'({pin_irq, bank_irq}), 0);
    rd(ra(1, 0), v); chk("R1 dir bank1", 128'(v), 128'(32'hFFFF_FFFF));
    rd(ra(2, 0), v); chk("R1 R12 dir bank2", 128'(v), 128'(32'h7F));
  endtask

  task automatic t_dir_out();
    logic [31:0] v;
    wr(ra(0, 0), 32'hFFFF_0000);
    chk("R3 oe bank0", 128'(pin_oe[31:0]), 128'(32'h0000_FFFF));
    wr(ra(1, 1), 32'hA5A5_0000);
    chk("R6 pin_out", 128'(pin_out[63:32]), 128'(32'hA5A5_0000));
    rd(ra(1, 2), v); chk("R6 read via set", 128'(v), 128'(32'hA5A5_0000));
    rd(ra(1, 3), v); chk("R6 read via clr", 128'(v), 128'(32'hA5A5_0000));
    wr(ra(1, 2), 32'h0000_00F0);
    chk("R4 set", 128'(pin_out[63:32]), 128'(32'hA5A5_00F0));
    wr(ra(1, 3), 32'hA000_0010);
    chk("R5 clr", 128'(pin_out[63:32]), 128'(32'h05A5_00E0));
    rd(ra(1, 1), v); chk("R2 R6 out reg", 128'(v), 128'(32'h05A5_00E0));
    wr(ra(2, 0), 32'hFFFF_FF80);
    chk("R3 oe bank2", 128'(pin_oe[70:64]), 128'(7'h7F));
    rd(ra(2, 0), v); chk("R12 bank2 dir upper", 128'(v), 0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    wr(ra(0, 2), 32'h20);               // drive pin 5 high, pad stays low
    rd(ra(0, 4), v); chk("R7 wired readback", 128'(v[5]), 0);
    @(negedge clk); pin_in[5] = 1'b1; pin_in[70] = 1'b1;
    rd(ra(0, 4), v); chk("R7 same cycle", 128'(v[5]), 0);
    @(negedge clk);
    rd(ra(0, 4), v); chk("R7 one edge", 128'(v[5]), 0);
    @(negedge clk);
    rd(ra(0, 4), v); chk("R7 two edges", 128'(v[5]), 1);
    rd(ra(2, 4), v); chk("R7 R12 bank2 input", 128'(v), 128'(32'h40));
  endtask

  task automatic t_arm();
    logic [31:0] v;
    wr(ra(0, 5), 32'h5);
    wr(ra(0, 6), 32'h1);
    rd(ra(0, 5), v); chk("R8 rise mask", 128'(v), 128'(32'h4));
    rd(ra(0, 6), v); chk("R8 rise mask via clr", 128'(v), 128'(32'h4));
    wr(ra(1, 7), 32'h300);
    wr(ra(1, 8), 32'h200);
    rd(ra(1, 7), v); chk("R9 fall mask", 128'(v), 128'(32'h100));
  endtask

  task automatic t_edges();
    logic [31:0] v;
    @(negedge clk); pin_in[2] = 1'b1; pin_in[0] = 1'b1; pin_in[40] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 not before third edge", 128'(pin_irq[2]), 0);
    @(negedge clk);
    chk("R10 rise irq", 128'(pin_irq[2]), 1);
    chk("R10 unarmed rise pin0", 128'(pin_irq[0]), 0);
    chk("R10 unarmed rise pin40", 128'(pin_irq[40]), 0);
    chk("R10 bank irq", 128'(bank_irq), 128'(3'b001));
    @(negedge clk); pin_in[40] = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R10 fall irq", 128'(pin_irq[40]), 1);
    chk("R10 bank irq both", 128'(bank_irq), 128'(3'b011));
    rd(ra(1, 9), v); chk("R2 R10 status bank1", 128'(v), 128'(32'h100));
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(ra(0, 9), 32'hFFFF_FFFB);
    chk("R11 zero bit kept", 128'(pin_irq[2]), 1);
    wr(ra(0, 9), 32'h4);
    chk("R11 cleared", 128'(pin_irq[2]), 0);
    chk("R11 bank irq", 128'(bank_irq), 128'(3'b010));
    rd(ra(1, 9), v); chk("R11 other bank kept", 128'(v), 128'(32'h100));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [70:0] out0, oe0;
    out0 = pin_out; oe0 = pin_oe;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    wr(8'h15, 32'hFFFF_FFFF);
    chk("R12 writes ignored out", 128'(pin_out), 128'(out0));
    chk("R12 writes ignored oe", 128'(pin_oe), 128'(oe0));
    rd(8'h00, v); chk("R12 read 0x00", 128'(v), 0);
    rd(8'h0C, v); chk("R12 read 0x0C", 128'(v), 0);
    rd(8'h88, v); chk("R12 read 0x88", 128'(v), 0);
    rd(8'h11, v); chk("R12 misaligned", 128'(v), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_input();
    t_arm();
    t_edges();
    t_w1c();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule